// File: doc/BRIEF.md
# Power-Management Function Configuration and SCI Logic

This block holds the configuration registers of a power-management function and turns its event bits into a system control interrupt. A byte-wide configuration port writes and reads the registers. Two of them are I/O base-address registers. One places a 128-byte power-management window and the other places a 16-byte SMBus window. Each window has its own enable bit. The block drives each aligned base and its enable bit to a downstream address decoder.

The event status bits come in from the event logic outside the block. The block combines them with a writable 16-bit event-enable register into a level-sensitive interrupt. It also produces the request that arms the next timer interrupt. The interrupt is held low while the interrupt-pin byte is zero.

Top module: `pmfn_cfg_top`

## Requirements
- R1: Config bytes 0x48 to 0x4B form the power-management base register. A write to 0x48 stores (data AND 0x80) OR 0x01. A write to 0x49 stores the full byte. Bytes 0x4A and 0x4B always read 0x00, and writes to them change nothing.
- R2: Config bytes 0x90 to 0x93 form the SMBus base register. A write to 0x90 stores (data AND 0xF0) OR 0x01. A write to 0x91 stores the full byte. Bytes 0x92 and 0x93 always read 0x00.
- R3: Byte 0x41 stores all 8 bits and reads them back. `pm_win_en` equals its bit 7. `pm_base` equals the power-management base register AND 0xFF80.
- R4: Byte 0xD2 keeps only its low 4 bits, and bits 7:4 read as 0. `smb_win_en` equals its bit 0. `smb_base` equals the SMBus base register AND 0xFFF0.
- R5: Bytes 0x44 (low) and 0x45 (high) form a 16-bit event-enable register that reads back as written. One cycle after the inputs change, `sci` is 1 if `evt_sts` AND enable has any of these bits set: bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC). Set enable and status bits at any other position have no effect.
- R6: Byte 0x3D is the interrupt-pin byte and reads back as written. While it is 0x00, `sci` is 0 one cycle later, whatever the status and enable bits are.
- R7: One cycle after the inputs change, `tmr_arm` is 1 exactly when enable bit 0 is 1 and `evt_sts` bit 0 is 0. The interrupt-pin byte does not affect it.
- R8: After reset, every config byte from 0x40 to 0xFF reads 0x00, except bytes 0x48 and 0x90, which read 0x01. Both window enables are 0, `sci` is 0 and the interrupt-pin byte reads the parameter `INTPIN_RST`.
- R9: A write takes effect at the clock edge where `cfg_we` is sampled. Reads and outputs show the new value right after that edge. Config bytes not named in R1 to R8 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config byte write strobe |
| cfg_addr | input | 8 | Config byte address |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Config read data for `cfg_addr` (combinational) |
| evt_sts | input | 16 | Event status bits |
| pm_base | output | IO_W | Aligned power-management window base |
| pm_win_en | output | 1 | Power-management window enable |
| smb_base | output | IO_W | Aligned SMBus window base |
| smb_win_en | output | 1 | SMBus window enable |
| sci | output | 1 | Level-sensitive system control interrupt |
| tmr_arm | output | 1 | Request to arm the next timer interrupt |

## Verification
The hardest case to reach from the ports is the interrupt's dependence on exact bit positions. A set status bit paired with a set enable bit must fire only at the four event positions, and only while the interrupt-pin byte is nonzero. The stimulus covers all 256 combinations of the four relevant status and enable bits. It fills every other status and enable bit with ones-heavy patterns, so any leak from an irrelevant position would raise `sci`. It then sweeps every interrupt-pin value with all events pending. A separate pass writes every config address in turn against a byte-level model. This catches masking errors in the base registers and writes that land on a neighbouring byte.

// File: rtl/pmfn_pkg.sv
package pmfn_pkg;

    localparam int CFG_AW = 8;

    typedef logic [7:0] cfg_byte_t;

    // Event bit positions inside the 16-bit status/enable words
    localparam int EVT_TMR    = 0;
    localparam int EVT_GLOCK  = 5;
    localparam int EVT_PWRBTN = 8;
    localparam int EVT_RTC    = 10;

    localparam logic [15:0] SCI_MASK = (16'h1 << EVT_TMR)    |
                                       (16'h1 << EVT_GLOCK)  |
                                       (16'h1 << EVT_PWRBTN) |
                                       (16'h1 << EVT_RTC);

    // Config byte offsets
    localparam cfg_byte_t OFS_INTPIN = 8'h3D;
    localparam cfg_byte_t OFS_PMCTL  = 8'h41;
    localparam cfg_byte_t OFS_EVTEN  = 8'h44;
    localparam cfg_byte_t OFS_PMBAR  = 8'h48;
    localparam cfg_byte_t OFS_SMBBAR = 8'h90;
    localparam cfg_byte_t OFS_SMBCTL = 8'hD2;

    localparam int PMCTL_EN_BIT  = 7;
    localparam int SMBCTL_EN_BIT = 0;

    typedef struct packed {
        cfg_byte_t   intpin;
        cfg_byte_t   pmctl;
        logic [15:0] evt_en;
        logic [3:0]  smbctl;
    } regs_t;

    typedef struct packed {
        logic sci;
        logic arm;
    } irq_t;

endpackage

// File: rtl/pmfn_iobar.sv
module pmfn_iobar
    import pmfn_pkg::*;
#(
    parameter int        IO_W   = 16,
    parameter int        ALIGN  = 7,
    parameter cfg_byte_t OFFSET = 8'h48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  cfg_byte_t       addr,
    input  cfg_byte_t       wdata,
    output logic [IO_W-1:0] val_q,
    output logic            rd_hit,
    output cfg_byte_t       rd_data
);

    localparam int             NBYTES = IO_W / 8;
    localparam logic [IO_W-1:0] KEEP  = {IO_W{1'b1}} << ALIGN;

    logic [IO_W-1:0] val_d;

    always_comb begin
        val_d = val_q;
        for (int k = 0; k < NBYTES; k++) begin
            if (wr_en && (addr == 8'(OFFSET + k))) begin
                val_d[k*8 +: 8] = wdata;
            end
        end
        // alignment bits clear, indicator bit set
        val_d = (val_d & KEEP) | IO_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= IO_W'(1);
        end else begin
            val_q <= val_d;
        end
    end

    always_comb begin
        rd_hit  = (addr[7:2] == OFFSET[7:2]);
        rd_data = '0;
        for (int k = 0; k < NBYTES; k++) begin
            if (addr[1:0] == 2'(k)) begin
                rd_data = val_q[k*8 +: 8];
            end
        end
        if (!rd_hit) begin
            rd_data = '0;
        end
    end

    // R1 and R2: untouched register holds its value
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr[7:2] == OFFSET[7:2])) |=> $stable(val_q));

    generate
        if (ALIGN < 8) begin : g_low_chk
            // R1 and R2: low-byte write is masked and gets bit 0 forced
            p_low_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (addr == OFFSET)) |=>
                    (val_q[7:0] == (($past(wdata) & KEEP[7:0]) | 8'h01)));
        end
    endgenerate

endmodule

// File: rtl/pmfn_cfg_regs.sv
module pmfn_cfg_regs
    import pmfn_pkg::*;
#(
    parameter cfg_byte_t INTPIN_RST = 8'h01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  cfg_byte_t   addr,
    input  cfg_byte_t   wdata,
    output regs_t       regs_q,
    output logic        rd_hit,
    output cfg_byte_t   rd_data
);

    regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (addr)
                OFS_INTPIN:          regs_d.intpin        = wdata;
                OFS_PMCTL:           regs_d.pmctl         = wdata;
                OFS_EVTEN:           regs_d.evt_en[7:0]   = wdata;
                8'(OFS_EVTEN + 1):   regs_d.evt_en[15:8]  = wdata;
                OFS_SMBCTL:          regs_d.smbctl        = wdata[3:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q        <= '0;
            regs_q.intpin <= INTPIN_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_hit  = 1'b1;
        rd_data = '0;
        unique case (addr)
            OFS_INTPIN:        rd_data = regs_q.intpin;
            OFS_PMCTL:         rd_data = regs_q.pmctl;
            OFS_EVTEN:         rd_data = regs_q.evt_en[7:0];
            8'(OFS_EVTEN + 1): rd_data = regs_q.evt_en[15:8];
            OFS_SMBCTL:        rd_data = {4'h0, regs_q.smbctl};
            default:           rd_hit  = 1'b0;
        endcase
    end

    // R4: only the low nibble of the SMBus control byte is kept
    p_smbctl_nib_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFS_SMBCTL)) |=> (regs_q.smbctl == $past(wdata[3:0])));

    // R3: window control byte stored whole
    p_pmctl_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFS_PMCTL)) |=> (regs_q.pmctl == $past(wdata)));

endmodule

// File: rtl/pmfn_sci.sv
module pmfn_sci
    import pmfn_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] evt_sts,
    input  logic [15:0] evt_en,
    input  cfg_byte_t   intpin,
    output logic        sci_q,
    output logic        arm_q
);

    irq_t irq_d;
    irq_t irq_q;

    always_comb begin
        irq_d.sci = (intpin != 8'h00) && ((evt_sts & evt_en & SCI_MASK) != 16'h0);
        irq_d.arm = evt_en[EVT_TMR] && !evt_sts[EVT_TMR];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign sci_q = irq_q.sci;
    assign arm_q = irq_q.arm;

    // R6: zero interrupt-pin byte silences the interrupt
    p_sci_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (intpin == 8'h00) |=> !sci_q);

    // R5: a pending enabled event on a live pin raises the interrupt
    p_sci_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((intpin != 8'h00) && (evt_sts[EVT_RTC] && evt_en[EVT_RTC])) |=> sci_q);

    // R7: timer armed only while enabled and not yet flagged
    p_arm_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_en[EVT_TMR] && !evt_sts[EVT_TMR]) |=> arm_q);
    p_arm_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_sts[EVT_TMR] |=> !arm_q);

endmodule

// File: rtl/pmfn_cfg_top.sv
module pmfn_cfg_top
    import pmfn_pkg::*;
#(
    parameter int        IO_W       = 16,
    parameter int        PM_ALIGN   = 7,
    parameter int        SMB_ALIGN  = 4,
    parameter cfg_byte_t INTPIN_RST = 8'h01
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [7:0]      cfg_addr,
    input  logic [7:0]      cfg_wdata,
    output logic [7:0]      cfg_rdata,
    input  logic [15:0]     evt_sts,
    output logic [IO_W-1:0] pm_base,
    output logic            pm_win_en,
    output logic [IO_W-1:0] smb_base,
    output logic            smb_win_en,
    output logic            sci,
    output logic            tmr_arm
);

    localparam int NBARS = 2;

    logic [IO_W-1:0] bar_val [NBARS];
    logic            bar_hit [NBARS];
    cfg_byte_t       bar_rd  [NBARS];

    regs_t     regs_q;
    logic      regs_hit;
    cfg_byte_t regs_rd;

    generate
        for (genvar g = 0; g < NBARS; g++) begin : g_bar
            localparam int        AL = (g == 0) ? PM_ALIGN : SMB_ALIGN;
            localparam cfg_byte_t OF = (g == 0) ? OFS_PMBAR : OFS_SMBBAR;
            pmfn_iobar #(
                .IO_W   (IO_W),
                .ALIGN  (AL),
                .OFFSET (OF)
            ) bar_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (cfg_we),
                .addr    (cfg_addr),
                .wdata   (cfg_wdata),
                .val_q   (bar_val[g]),
                .rd_hit  (bar_hit[g]),
                .rd_data (bar_rd[g])
            );
        end
    endgenerate

    pmfn_cfg_regs #(
        .INTPIN_RST (INTPIN_RST)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .regs_q  (regs_q),
        .rd_hit  (regs_hit),
        .rd_data (regs_rd)
    );

    pmfn_sci sci_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_sts (evt_sts),
        .evt_en  (regs_q.evt_en),
        .intpin  (regs_q.intpin),
        .sci_q   (sci),
        .arm_q   (tmr_arm)
    );

    always_comb begin
        cfg_rdata = regs_hit ? regs_rd : 8'h00;
        for (int g = 0; g < NBARS; g++) begin
            if (bar_hit[g]) begin
                cfg_rdata = cfg_rdata | bar_rd[g];
            end
        end
    end

    assign pm_base    = bar_val[0] & ({IO_W{1'b1}} << PM_ALIGN);
    assign smb_base   = bar_val[1] & ({IO_W{1'b1}} << SMB_ALIGN);
    assign pm_win_en  = regs_q.pmctl[PMCTL_EN_BIT];
    assign smb_win_en = regs_q.smbctl[SMBCTL_EN_BIT];

    // R9: at most one register group answers a read address
    p_rd_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({regs_hit, bar_hit[0], bar_hit[1]}));

    // R8: first cycle out of reset has both windows closed
    p_rst_closed_r8: assert property (@(posedge clk)
        !rst_n |=> (!pm_win_en && !smb_win_en && !sci));

endmodule

// File: tb/pmfn_cfg_top_tb_top.sv
module pmfn_cfg_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [15:0] evt_sts = 16'h0000;
    logic [15:0] pm_base;
    logic        pm_win_en;
    logic [15:0] smb_base;
    logic        smb_win_en;
    logic        sci;
    logic        tmr_arm;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0]  m_pin;
    logic [7:0]  m_pmctl;
    logic [15:0] m_en;
    logic [15:0] m_pmbar;
    logic [15:0] m_smbbar;
    logic [7:0]  m_smbctl;

    always #2 clk = ~clk;

    pmfn_cfg_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .evt_sts    (evt_sts),
        .pm_base    (pm_base),
        .pm_win_en  (pm_win_en),
        .smb_base   (smb_base),
        .smb_win_en (smb_win_en),
        .sci        (sci),
        .tmr_arm    (tmr_arm)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mdl_reset();
        m_pin = 8'h01; m_pmctl = 8'h00; m_en = 16'h0000;
        m_pmbar = 16'h0001; m_smbbar = 16'h0001; m_smbctl = 8'h00;
    endtask

    task automatic mdl_wr(input logic [7:0] a, input logic [7:0] v);
        case (a)
            8'h3D: m_pin = v;
            8'h41: m_pmctl = v;
            8'h44: m_en[7:0] = v;
            8'h45: m_en[15:8] = v;
            8'h48: m_pmbar[7:0] = (v & 8'h80) | 8'h01;
            8'h49: m_pmbar[15:8] = v;
            8'h90: m_smbbar[7:0] = (v & 8'hF0) | 8'h01;
            8'h91: m_smbbar[15:8] = v;
            8'hD2: m_smbctl = v & 8'h0F;
            default: ;
        endcase
    endtask

    function automatic logic [7:0] mdl_rd(input logic [7:0] a);
        case (a)
            8'h3D: return m_pin;
            8'h41: return m_pmctl;
            8'h44: return m_en[7:0];
            8'h45: return m_en[15:8];
            8'h48: return m_pmbar[7:0];
            8'h49: return m_pmbar[15:8];
            8'h90: return m_smbbar[7:0];
            8'h91: return m_smbbar[15:8];
            8'hD2: return m_smbctl;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [15:0] spread(input logic [3:0] n);
        return {5'b0, n[3], 1'b0, n[2], 2'b0, n[1], 4'b0, n[0]};
    endfunction

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        mdl_wr(a, v);
    endtask

    task automatic read_check(input string req, input logic [7:0] a);
        cfg_addr = a;
        #1;
        check(req, {24'h0, cfg_rdata}, {24'h0, mdl_rd(a)});
    endtask

    task automatic outs_check(input string req);
        check(req, {16'h0, pm_base}, {16'h0, m_pmbar & 16'hFF80});
        check(req, {31'h0, pm_win_en}, {31'h0, m_pmctl[7]});
        check(req, {16'h0, smb_base}, {16'h0, m_smbbar & 16'hFFF0});
        check(req, {31'h0, smb_win_en}, {31'h0, m_smbctl[0]});
    endtask

    task automatic irq_check(input string req);
        check(req, {31'h0, sci},
              {31'h0, (m_pin != 8'h00) && ((evt_sts & m_en & 16'h0521) != 16'h0)});
        check("R7 timer arm", {31'h0, tmr_arm}, {31'h0, m_en[0] & ~evt_sts[0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        mdl_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state across the whole space
        for (int a = 0; a < 256; a++) read_check("R8 reset contents", 8'(a));
        outs_check("R8 reset outputs");
        check("R8 reset sci", {31'h0, sci}, 32'h0);

        // R1: every data value at each base byte
        for (int v = 0; v < 256; v++) begin
            cfg_write(8'h48, 8'(v)); read_check("R1 pm base low", 8'h48); outs_check("R1 pm base out");
            cfg_write(8'h49, 8'(v)); read_check("R1 pm base high", 8'h49);
            cfg_write(8'h4A, 8'(v)); read_check("R1 pm base byte2", 8'h4A);
            cfg_write(8'h4B, 8'(v)); read_check("R1 pm base byte3", 8'h4B);
        end

        // R2
        for (int v = 0; v < 256; v++) begin
            cfg_write(8'h90, 8'(v)); read_check("R2 smb base low", 8'h90); outs_check("R2 smb base out");
            cfg_write(8'h91, 8'(v)); read_check("R2 smb base high", 8'h91);
            cfg_write(8'h92, 8'(v)); read_check("R2 smb base byte2", 8'h92);
            cfg_write(8'h93, 8'(v)); read_check("R2 smb base byte3", 8'h93);
        end

        // R3 and R4 control bytes
        for (int v = 0; v < 256; v++) begin
            cfg_write(8'h41, 8'(v)); read_check("R3 pm ctl", 8'h41); outs_check("R3 pm window");
            cfg_write(8'hD2, 8'(v)); read_check("R4 smb ctl", 8'hD2); outs_check("R4 smb window");
        end

        // R5: exhaustive over the four event positions, other bits filled
        cfg_write(8'h3D, 8'h01);
        for (int m = 0; m < 16; m++) begin
            for (int n = 0; n < 16; n++) begin
                logic [15:0] en_v;
                en_v = spread(4'(m)) | (16'hFADE & ~16'h0521);
                cfg_write(8'h44, en_v[7:0]);
                cfg_write(8'h45, en_v[15:8]);
                evt_sts = spread(4'(n)) | (16'hFFFF & ~16'h0521);
                @(negedge clk);
                irq_check("R5 event combine");
            end
        end
        read_check("R5 enable readback low", 8'h44);
        read_check("R5 enable readback high", 8'h45);

        // R6: interrupt-pin byte sweep with all events pending
        cfg_write(8'h44, 8'hFF);
        cfg_write(8'h45, 8'hFF);
        evt_sts = 16'hFFFF;
        for (int p = 0; p < 256; p++) begin
            cfg_write(8'h3D, 8'(p));
            @(negedge clk);
            read_check("R6 pin readback", 8'h3D);
            irq_check("R6 pin gate");
        end

        // R7: timer arm under pin zero
        cfg_write(8'h3D, 8'h00);
        for (int k = 0; k < 4; k++) begin
            cfg_write(8'h44, {7'h0, k[0]});
            evt_sts = {15'h0, k[1]};
            @(negedge clk);
            irq_check("R7 arm with pin zero");
        end

        // R9: write every address, check its byte and all outputs
        for (int a = 0; a < 256; a++) begin
            cfg_write(8'(a), 8'(a) ^ 8'h5A);
            read_check("R9 address sweep", 8'(a));
            outs_check("R9 outputs after write");
        end
        for (int a = 0; a < 256; a++) read_check("R9 final contents", 8'(a));

        // R8: reset after configuration
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mdl_reset();
        for (int a = 64; a < 256; a++) read_check("R8 second reset", 8'(a));
        outs_check("R8 second reset outputs");
        check("R8 second reset sci", {31'h0, sci}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule